// File: doc/BRIEF.md
# CPU clock mode controller

This block turns a free-running oscillator clock into the processor clock. One 8-bit control register, reached over a simple select/write register bus, holds two settings. A slow-mode bit runs the processor on the oscillator clock divided by 32. A clock-out bit puts the processor clock on a pin that is otherwise shared with general-purpose output data.

The divided clock is the top bit of a 5-bit counter. This counter runs on every oscillator cycle in both modes, so the phase of the slow clock is set only by the time since reset. A mode request written over the bus takes effect at the first falling oscillator edge at which the divided clock is also low. Both clock sources are low at the moment of the switch, so the processor clock never shows a shortened pulse.

Top module: `cpu_clk_mode_ctrl`

## Requirements
- R1: After reset the register reads 00h, `cpu_clk_o` follows `clk_osc_i` and `pin_o` carries `gpio_out_i`.
- R2: Register bits 7 to 2 ignore writes, always read as 0 and have no effect on any output.
- R3: Bit 0 (slow) and bit 1 (clock out) read back as last written. `bus_rdata_o` carries the register only while `bus_sel_i` is 1 and `bus_wr_i` is 0, and reads 00h otherwise. A write occurs on the rising oscillator edge at which `bus_sel_i` and `bus_wr_i` are both 1.
- R4: With bit 0 at 0 (once the switch has taken effect), `cpu_clk_o` equals `clk_osc_i`.
- R5: With bit 0 at 1 (once the switch has taken effect), `cpu_clk_o` has a period of 32 oscillator cycles, 16 high and 16 low. Its phase comes from a 5-bit counter that is cleared by reset and then counts every rising edge. The clock is high after the rising edges whose count modulo 32 lies between 16 and 31.
- R6: A change of bit 0 takes effect at the first falling oscillator edge at which the divided clock is low. Until that edge the previous mode continues.
- R7: `cpu_clk_o` never has a high or low pulse shorter than half an oscillator period.
- R8: With bit 1 at 1, `pin_o` carries `cpu_clk_o`.
- R9: With bit 1 at 0, `pin_o` carries `gpio_out_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc_i | input | 1 | Oscillator clock; also clocks the register bus |
| rst_ni | input | 1 | Asynchronous active-low reset, released in step with the clock |
| bus_sel_i | input | 1 | Register select |
| bus_wr_i | input | 1 | Write strobe (1 = write, 0 = read) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, 00h when no read is under way |
| gpio_out_i | input | 1 | General-purpose data for the shared pin |
| pin_o | output | 1 | Shared pin: processor clock or general-purpose data |
| cpu_clk_o | output | 1 | Processor clock |

## Verification
Four properties are checked on every cycle: reserved read bits stay at zero, a write lands in the control bits, the divided clock changes level exactly every 16 oscillator cycles, and the active mode changes only at a falling edge where the divided clock is low. The return of the pin to general-purpose data after a clear write is also checked each cycle. Only the bench scenarios can show the waveform of the processor clock itself. These cover the deferral of a mode request written while the divided clock is high, the absolute phase of the slow clock relative to reset, and the absence of short pulses across both directions of switching. The bench samples the clock at both half-cycles to tell the two modes apart.

// File: rtl/ccm_pkg.sv
`timescale 1ns/1ps
package ccm_pkg;
  localparam int unsigned SLOW_BIT = 0;
  localparam int unsigned OE_BIT   = 1;

  typedef struct packed {
    logic out_en;
    logic slow;
  } ctl_t;
endpackage

// File: rtl/ccm_ctl_reg.sv
`timescale 1ns/1ps
module ccm_ctl_reg
  import ccm_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output ctl_t             ctl_o
);
  localparam logic [REG_W-1:0] LIVE_MASK = REG_W'((1 << OE_BIT) | (1 << SLOW_BIT));

  ctl_t ctl_q, ctl_d;
  logic wr_en;
  logic rd_en;
  logic unused_wbits;

  assign wr_en = sel_i & wr_i;
  assign rd_en = sel_i & ~wr_i;
  assign unused_wbits = ^(wdata_i & ~LIVE_MASK);

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d.out_en = wdata_i[OE_BIT];
      ctl_d.slow   = wdata_i[SLOW_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      rdata_o[OE_BIT]   = ctl_q.out_en;
      rdata_o[SLOW_BIT] = ctl_q.slow;
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/ccm_divider.sv
`timescale 1ns/1ps
module ccm_divider #(
  parameter int unsigned DIV_LOG2 = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic div_clk_o
);
  localparam int unsigned CNT_W = DIV_LOG2;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign div_clk_o = cnt_q[CNT_W-1];
endmodule

// File: rtl/ccm_clk_switch.sv
`timescale 1ns/1ps
module ccm_clk_switch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_req_i,
  input  logic div_clk_i,
  output logic active_slow_o,
  output logic cpu_clk_o
);
  logic act_q, act_d;
  logic both_low;

  // Sampled on the falling edge: the fast clock is low there, and the
  // divided clock only moves on rising edges, so it is stable here.
  assign both_low = ~div_clk_i;

  always_comb begin
    act_d = act_q;
    if (both_low) begin
      act_d = slow_req_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
    end else begin
      act_q <= act_d;
    end
  end

  assign cpu_clk_o     = act_q ? div_clk_i : clk_i;
  assign active_slow_o = act_q;
endmodule

// File: rtl/ccm_pin_mux.sv
`timescale 1ns/1ps
module ccm_pin_mux (
  input  logic out_en_i,
  input  logic cpu_clk_i,
  input  logic gpio_i,
  output logic pin_o
);
  assign pin_o = out_en_i ? cpu_clk_i : gpio_i;
endmodule

// File: rtl/cpu_clk_mode_ctrl.sv
`timescale 1ns/1ps
module cpu_clk_mode_ctrl
  import ccm_pkg::*;
#(
  parameter int unsigned REG_W    = 8,
  parameter int unsigned DIV_LOG2 = 5
) (
  input  logic             clk_osc_i,
  input  logic             rst_ni,
  input  logic             bus_sel_i,
  input  logic             bus_wr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  input  logic             gpio_out_i,
  output logic             pin_o,
  output logic             cpu_clk_o
);
  ctl_t ctl;
  logic ctl_slow;
  logic ctl_oe;
  logic div_clk;
  logic active_slow;

  ccm_ctl_reg #(.REG_W(REG_W)) u_reg (
    .clk_i   (clk_osc_i),
    .rst_ni  (rst_ni),
    .sel_i   (bus_sel_i),
    .wr_i    (bus_wr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .ctl_o   (ctl)
  );

  assign ctl_slow = ctl.slow;
  assign ctl_oe   = ctl.out_en;

  ccm_divider #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk_i     (clk_osc_i),
    .rst_ni    (rst_ni),
    .div_clk_o (div_clk)
  );

  ccm_clk_switch u_sw (
    .clk_i         (clk_osc_i),
    .rst_ni        (rst_ni),
    .slow_req_i    (ctl_slow),
    .div_clk_i     (div_clk),
    .active_slow_o (active_slow),
    .cpu_clk_o     (cpu_clk_o)
  );

  ccm_pin_mux u_pin (
    .out_en_i  (ctl_oe),
    .cpu_clk_i (cpu_clk_o),
    .gpio_i    (gpio_out_i),
    .pin_o     (pin_o)
  );
endmodule

// File: rtl/ccm_checker.sv
`timescale 1ns/1ps
module ccm_checker #(
  parameter int unsigned REG_W    = 8,
  parameter int unsigned DIV_LOG2 = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             wr_i,
  input logic [REG_W-1:0] wdata_i,
  input logic [REG_W-1:0] rdata_i,
  input logic             slow_i,
  input logic             oe_i,
  input logic             div_i,
  input logic             act_i,
  input logic             gpio_i,
  input logic             pin_i
);
  localparam int unsigned HALF  = 1 << (DIV_LOG2 - 1);
  localparam int unsigned RUN_W = DIV_LOG2 + 1;

  logic             div_prev;
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_prev <= 1'b0;
      run_len  <= '0;
    end else begin
      div_prev <= div_i;
      if (div_i != div_prev) begin
        run_len <= RUN_W'(1);
      end else begin
        run_len <= run_len + RUN_W'(1);
      end
    end
  end

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_i[REG_W-1:2] == '0);

  p_idle_rdata_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && !wr_i) |-> rdata_i == '0);

  p_wr_take_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i) |=> (slow_i == $past(wdata_i[0])) && (oe_i == $past(wdata_i[1])));

  p_half_period_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i != div_prev) |-> run_len == RUN_W'(HALF));

  p_switch_low_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (act_i != $past(act_i)) |-> !$past(div_i));

  p_gpio_pin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && !wdata_i[1]) |=> pin_i == gpio_i);
endmodule

bind cpu_clk_mode_ctrl ccm_checker #(.REG_W(REG_W), .DIV_LOG2(DIV_LOG2)) u_chk (
  .clk_i   (clk_osc_i),
  .rst_ni  (rst_ni),
  .sel_i   (bus_sel_i),
  .wr_i    (bus_wr_i),
  .wdata_i (bus_wdata_i),
  .rdata_i (bus_rdata_o),
  .slow_i  (ctl_slow),
  .oe_i    (ctl_oe),
  .div_i   (div_clk),
  .act_i   (active_slow),
  .gpio_i  (gpio_out_i),
  .pin_i   (pin_o)
);

// File: tb/cpu_clk_mode_ctrl_tb.sv
`timescale 1ns/1ps
module cpu_clk_mode_ctrl_tb;
  logic       clk;
  logic       rst_n;
  logic       sel;
  logic       wr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       gpio;
  logic       pin;
  logic       cpu_clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc;
  bit done = 0;

  cpu_clk_mode_ctrl u_dut (
    .clk_osc_i   (clk),
    .rst_ni      (rst_n),
    .bus_sel_i   (sel),
    .bus_wr_i    (wr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .gpio_out_i  (gpio),
    .pin_o       (pin),
    .cpu_clk_o   (cpu_clk)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Pulse-width monitor on the processor clock (R7)
  bit      mon_en = 0;
  realtime t_last = 0.0;
  int      short_cnt = 0;
  always @(cpu_clk) begin
    if (mon_en && ($realtime - t_last) < 9.999) short_cnt++;
    t_last = $realtime;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic bus_write(input logic [7:0] v);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; wdata = v;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic bus_read(output logic [7:0] v);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0;
    #2 v = rdata;
    sel = 1'b0;
  endtask

  task automatic wait_phase(input int m);
    do @(negedge clk); while ((cyc % 32) != m);
  endtask

  task automatic fast_clk_count(input int n, output int bad);
    bad = 0;
    repeat (n) begin
      @(posedge clk); #5 if (cpu_clk !== 1'b1) bad++;
      @(negedge clk); #5 if (cpu_clk !== 1'b0) bad++;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    int bad;
    bus_read(v);
    chk(v == 8'h00, "R1 reset read", v, 0);
    gpio = 1'b1; #1;
    chk(pin == 1'b1, "R1 pin gpio high", pin, 1);
    gpio = 1'b0; #1;
    chk(pin == 1'b0, "R1 pin gpio low", pin, 0);
    fast_clk_count(4, bad);
    chk(bad == 0, "R1 clock after reset", bad, 0);
  endtask

  task automatic t_fast();
    int bad;
    fast_clk_count(10, bad);
    chk(bad == 0, "R4 fast mode follows oscillator", bad, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    bus_write(8'hFF);
    bus_read(v);
    chk(v == 8'h03, "R2 reserved masked", v, 3);
    bus_write(8'hFC);
    bus_read(v);
    chk(v == 8'h00, "R2 reserved-only write", v, 0);
    gpio = 1'b1; #1;
    chk(pin == 1'b1, "R2 reserved write no effect on pin", pin, 1);
    gpio = 1'b0;
    bus_write(8'h02);
    bus_read(v);
    chk(v == 8'h02, "R3 readback clock-out bit", v, 2);
    @(negedge clk); #2;
    chk(rdata == 8'h00, "R3 idle read data", rdata, 0);
    sel = 1'b1; wr = 1'b1; wdata = 8'h02; #2;
    chk(rdata == 8'h00, "R3 read data during write", rdata, 0);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic t_pin_gpio();
    bus_write(8'h00);
    for (int i = 0; i < 4; i++) begin
      gpio = i[0];
      @(posedge clk); #3;
      chk(pin == i[0], "R9 pin follows gpio", pin, i[0]);
    end
  endtask

  task automatic t_pin_clk();
    int bad = 0;
    bus_write(8'h02);
    gpio = 1'b1;
    repeat (6) begin
      @(posedge clk); #5 if (pin !== 1'b1) bad++;
      @(negedge clk); #5 if (pin !== 1'b0) bad++;
    end
    chk(bad == 0, "R8 pin carries fast clock", bad, 0);
    gpio = 1'b0;
  endtask

  task automatic t_switch_up();
    int bad = 0;
    wait_phase(19);
    bus_write(8'h03);
    while ((cyc % 32) != 0) begin
      #5 if (cpu_clk !== 1'b0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R6 fast kept while divided clock high", bad, 0);
    bad = 0;
    #5 if (cpu_clk !== 1'b0) bad++;
    repeat (10) begin
      @(posedge clk); #5 if (cpu_clk !== 1'b0) bad++;
    end
    chk(bad == 0, "R6 slow taken at divided low", bad, 0);
  endtask

  task automatic t_slow();
    int bad = 0;
    int pbad = 0;
    logic e;
    repeat (70) begin
      @(negedge clk); #5;
      e = ((cyc % 32) >= 16);
      if (cpu_clk !== e) bad++;
      if (pin !== e) pbad++;
    end
    chk(bad == 0, "R5 slow clock phase and period", bad, 0);
    chk(pbad == 0, "R8 pin carries slow clock", pbad, 0);
  endtask

  task automatic t_switch_down();
    int bad = 0;
    wait_phase(19);
    bus_write(8'h02);
    while ((cyc % 32) != 0) begin
      #5 if (cpu_clk !== 1'b1) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R6 slow kept while divided clock high", bad, 0);
    #5 chk(cpu_clk == 1'b0, "R6 low at switch point", cpu_clk, 0);
    fast_clk_count(8, bad);
    chk(bad == 0, "R4 fast restored after switch", bad, 0);
  endtask

  task automatic t_glitch();
    chk(short_cnt == 0, "R7 no short clock pulse", short_cnt, 0);
  endtask

  initial begin
    rst_n = 1'b0; sel = 1'b0; wr = 1'b0; wdata = 8'h00; gpio = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    t_reset();
    t_fast();
    t_regs();
    t_pin_gpio();
    t_pin_clk();
    t_switch_up();
    t_slow();
    t_switch_down();
    t_glitch();
    done = 1'b1;
    summary();
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end
endmodule